// File: doc/BRIEF.md
# Cache-Inhibited Instruction Line Buffer

This block sits beside the instruction fetch path. It keeps one instruction line that was fetched by a burst from a cache-inhibited region. Later instruction fetches that fall inside that line are answered from the kept copy, and no external bus access is made for them. Only plain instruction reads (access type 0) to an inhibited region may use the buffer, and only while the enable input is high. Every other inhibited fetch is sent to the bus as a single access. Fetches to cacheable space are left to the main cache and are ignored here.

The line holds `WORDS` 32-bit words. It is filled by one burst that returns the words in order, starting at word 0 of the line-aligned address. The copy lasts until one of three events: an invalidate-all, a main-cache miss that starts a line fill, or a fresh inhibited burst that replaces it. Data writes to the buffered line are passed to the bus and are not applied to the copy, so later fetches of that line return the old contents. A fetch that needs a word of a line still being filled stalls until that word is in. Addresses on the fetch side are 32-bit-word addresses, and the low `log2(WORDS)` bits select the word within the line.

Top module: `ci_fetch_buffer`

## Requirements
- R1: While `buf_en` is 0, an inhibited fetch never hits or stalls, and it raises `bus_req` with `bus_burst` 0 and `bus_addr` equal to the fetch address. The stored line is kept, so it hits again once `buf_en` returns to 1.
- R2: An inhibited fetch whose `req_type` is not 0 never hits and is sent as a single access (`bus_req` 1, `bus_burst` 0). A fetch with `req_inhibit` 0 raises neither `fetch_hit` nor `bus_req`.
- R3: An eligible fetch (enabled, inhibited, type 0) that misses while no fill is running raises `bus_req` and `bus_burst` in the same cycle, with `bus_addr` line-aligned (word bits 0). The next `WORDS` beats are stored as words 0, 1, … in order, and the fill ends after the last beat.
- R4: An eligible fetch to a word of the buffered line that is present raises `fetch_hit` in the same cycle, with `fetch_data` equal to that word and `bus_req` 0.
- R5: An eligible fetch to the line being filled, whose word has not arrived yet, raises `fetch_stall` with `bus_req` 0. It hits from the cycle after the clock edge that stores that word. An eligible fetch to any other line during a fill also stalls.
- R6: A one-cycle `inval_all` or `icache_fill` drops the line. From the next cycle, fetches to it miss and start a new burst. A fill that is running is abandoned, and beats that arrive afterwards are ignored.
- R7: A new inhibited burst to another line replaces the buffered line, so fetches to the old line then miss.
- R8: A data write (`wr_valid`, `wr_line` = line address) to the buffered line does not change it. Later fetches still hit and return the old words.
- R9: After reset the buffer is empty, and the first eligible fetch starts a burst.
- R10: If a burst starts in the same cycle as `inval_all` or `icache_fill`, the new fill goes ahead, and its line hits once all its beats are in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| buf_en | input | 1 | Enables use of the buffer |
| req_valid | input | 1 | Instruction fetch request present |
| req_addr | input | AW | Fetch word address |
| req_type | input | 2 | Access type, 0 = normal instruction read |
| req_inhibit | input | 1 | Fetch targets a cache-inhibited region |
| beat_valid | input | 1 | Burst beat returned from the bus |
| beat_data | input | DW | Burst beat data |
| wr_valid | input | 1 | Data write notification |
| wr_line | input | AW-log2(WORDS) | Line address of the data write |
| inval_all | input | 1 | Invalidate-all pulse |
| icache_fill | input | 1 | Main-cache miss starting a line fill |
| fetch_hit | output | 1 | Fetch served from the buffer |
| fetch_data | output | DW | Word returned on a hit |
| fetch_stall | output | 1 | Fetch must wait for a pending beat |
| bus_req | output | 1 | External bus access needed |
| bus_burst | output | 1 | Access is a line burst, not a single access |
| bus_addr | output | AW | Address of the bus access |

## Verification
Hit, stall and bus-request outputs are combinational on the fetch inputs and the stored state. They are therefore due in the same cycle as the fetch, and the bench samples them one time unit after driving inputs at the falling edge. A beat, a drop event or a write takes effect at the next rising edge, so every check that depends on it is made in the half-cycle after the falling edge that follows that rising edge. Probes that would otherwise start a fill drop `req_valid` before the next rising edge, so a check for a miss leaves the stored state as it was.

// File: rtl/ci_fetch_buffer_pkg.sv
package ci_fetch_buffer_pkg;
  typedef enum logic {FB_IDLE = 1'b0, FB_FILL = 1'b1} fb_state_e;
endpackage

// File: rtl/ci_fb_ctrl.sv
module ci_fb_ctrl
  import ci_fetch_buffer_pkg::*;
#(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDXW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_start,
  input  logic            drop,
  input  logic            beat_valid,
  output logic            fill_busy,
  output logic            beat_take,
  output logic [IDXW-1:0] beat_idx
);
  fb_state_e       state_q;
  logic [IDXW-1:0] cnt_q;
  logic            last_beat;

  assign fill_busy = (state_q == FB_FILL);
  assign beat_take = fill_busy && beat_valid && !drop;
  assign beat_idx  = cnt_q;
  assign last_beat = (cnt_q == IDXW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FB_IDLE;
      cnt_q   <= '0;
    end else if (fill_start) begin
      state_q <= FB_FILL;
      cnt_q   <= '0;
    end else if (drop) begin
      state_q <= FB_IDLE;
      cnt_q   <= '0;
    end else if (beat_take) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) state_q <= FB_IDLE;
    end
  end

  // R3: the fill closes after the last beat of the line
  assert_fill_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_take && last_beat && !fill_start) |=> (state_q == FB_IDLE));

  // R6: a drop without a new start leaves no fill running
  assert_drop_stops_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !fill_start) |=> !fill_busy);
endmodule

// File: rtl/ci_fb_store.sv
module ci_fb_store #(
  parameter int unsigned AW    = 30,
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDXW = $clog2(WORDS),
  localparam int unsigned TAGW = AW - IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_start,
  input  logic [TAGW-1:0] fill_tag,
  input  logic            drop,
  input  logic            beat_take,
  input  logic [IDXW-1:0] beat_idx,
  input  logic [DW-1:0]   beat_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [TAGW-1:0] tag_q,
  output logic            tag_valid_q,
  output logic [WORDS-1:0] present_q,
  output logic [DW-1:0]   rd_word
);
  logic [DW-1:0] line_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q       <= '0;
      tag_valid_q <= 1'b0;
    end else if (fill_start) begin
      tag_q       <= fill_tag;
      tag_valid_q <= 1'b1;
    end else if (drop) begin
      tag_valid_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic wr_here;
    assign wr_here = beat_take && (beat_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  present_q[g] <= 1'b0;
      else if (fill_start || drop) present_q[g] <= 1'b0;
      else if (wr_here)            present_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_here && !fill_start) line_q[g] <= beat_data;
    end
  end

  assign rd_word = line_q[rd_idx];

  // R6: a drop empties the line
  assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !fill_start) |=> (!tag_valid_q && present_q == '0));

  // R10: a start wins over a drop in the same cycle
  assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_start && drop) |=> (tag_valid_q && present_q == '0));

  // R5: words become present one at a time during a fill
  assert_one_word_per_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_take && !fill_start) |=> ($countones(present_q) == $countones($past(present_q)) + 1));
endmodule

// File: rtl/ci_fb_lookup.sv
module ci_fb_lookup #(
  parameter int unsigned AW    = 30,
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDXW = $clog2(WORDS),
  localparam int unsigned TAGW = AW - IDXW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_en,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_type,
  input  logic             req_inhibit,
  input  logic [TAGW-1:0]  tag_q,
  input  logic             tag_valid_q,
  input  logic [WORDS-1:0] present_q,
  input  logic             fill_busy,
  input  logic [DW-1:0]    rd_word,
  output logic [IDXW-1:0]  rd_idx,
  output logic             fill_start,
  output logic [TAGW-1:0]  fill_tag,
  output logic             fetch_hit,
  output logic [DW-1:0]    fetch_data,
  output logic             fetch_stall,
  output logic             bus_req,
  output logic             bus_burst,
  output logic [AW-1:0]    bus_addr
);
  function automatic logic [TAGW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:IDXW];
  endfunction

  function automatic logic [IDXW-1:0] word_of(input logic [AW-1:0] a);
    return a[IDXW-1:0];
  endfunction

  function automatic logic [AW-1:0] line_base(input logic [TAGW-1:0] t);
    return {t, {IDXW{1'b0}}};
  endfunction

  logic eligible, tag_hit, word_here, single_acc;

  assign rd_idx     = word_of(req_addr);
  assign fill_tag   = line_of(req_addr);
  assign eligible   = req_valid && buf_en && req_inhibit && (req_type == 2'd0);
  assign tag_hit    = tag_valid_q && (tag_q == fill_tag);
  assign word_here  = present_q[rd_idx];

  assign fetch_hit   = eligible && tag_hit && word_here;
  assign fetch_data  = rd_word;
  assign fetch_stall = eligible && ((tag_hit && !word_here) || (!tag_hit && fill_busy));
  assign fill_start  = eligible && !tag_hit && !fill_busy;
  assign single_acc  = req_valid && req_inhibit && !eligible;
  assign bus_req     = single_acc || fill_start;
  assign bus_burst   = fill_start;
  assign bus_addr    = fill_start ? line_base(fill_tag) : req_addr;

  // R4: a hit never reaches the bus
  assert_hit_no_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> !bus_req);

  // R5: a stalled fetch neither hits nor goes to the bus
  assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (!fetch_hit && !bus_req));

  // R1: disabled buffer sends inhibited fetches out singly
  assert_disabled_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inhibit && !buf_en) |-> (!fetch_hit && bus_req && !bus_burst));

  // R2: other access types never use the buffer
  assert_type_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type != 2'd0) |-> (!fetch_hit && !bus_burst && !fetch_stall));

  // R3: a burst is line-aligned
  assert_burst_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> (bus_addr[IDXW-1:0] == '0));
endmodule

// File: rtl/ci_fetch_buffer.sv
module ci_fetch_buffer #(
  parameter int unsigned AW    = 30,
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDXW = $clog2(WORDS),
  localparam int unsigned TAGW = AW - IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_en,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_type,
  input  logic            req_inhibit,
  input  logic            beat_valid,
  input  logic [DW-1:0]   beat_data,
  input  logic            wr_valid,
  input  logic [TAGW-1:0] wr_line,
  input  logic            inval_all,
  input  logic            icache_fill,
  output logic            fetch_hit,
  output logic [DW-1:0]   fetch_data,
  output logic            fetch_stall,
  output logic            bus_req,
  output logic            bus_burst,
  output logic [AW-1:0]   bus_addr
);
  logic             fill_start, drop, fill_busy, beat_take;
  logic [IDXW-1:0]  beat_idx, rd_idx;
  logic [TAGW-1:0]  fill_tag, tag_q;
  logic             tag_valid_q;
  logic [WORDS-1:0] present_q;
  logic [DW-1:0]    rd_word;
  logic             wr_on_line;

  assign drop       = inval_all || icache_fill;
  assign wr_on_line = wr_valid && tag_valid_q && (wr_line == tag_q);

  ci_fb_lookup #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_lookup (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_type(req_type), .req_inhibit(req_inhibit),
    .tag_q(tag_q), .tag_valid_q(tag_valid_q), .present_q(present_q),
    .fill_busy(fill_busy), .rd_word(rd_word), .rd_idx(rd_idx),
    .fill_start(fill_start), .fill_tag(fill_tag), .fetch_hit(fetch_hit),
    .fetch_data(fetch_data), .fetch_stall(fetch_stall), .bus_req(bus_req),
    .bus_burst(bus_burst), .bus_addr(bus_addr)
  );

  ci_fb_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .drop(drop),
    .beat_valid(beat_valid), .fill_busy(fill_busy), .beat_take(beat_take),
    .beat_idx(beat_idx)
  );

  ci_fb_store #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_tag(fill_tag),
    .drop(drop), .beat_take(beat_take), .beat_idx(beat_idx),
    .beat_data(beat_data), .rd_idx(rd_idx), .tag_q(tag_q),
    .tag_valid_q(tag_valid_q), .present_q(present_q), .rd_word(rd_word)
  );

  // R8: a write to the kept line leaves it untouched
  assert_write_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on_line && !fill_start && !drop && !beat_take) |=>
      ($stable(present_q) && $stable(tag_q) && tag_valid_q));
endmodule

// File: tb/ci_fetch_buffer_tb.sv
module ci_fetch_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int WORDS = 4;
  localparam int TAGW = AW - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic buf_en = 1'b1, req_valid = 1'b0, req_inhibit = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_type = '0;
  logic beat_valid = 1'b0, wr_valid = 1'b0, inval_all = 1'b0, icache_fill = 1'b0;
  logic [DW-1:0] beat_data = '0;
  logic [TAGW-1:0] wr_line = '0;
  logic fetch_hit, fetch_stall, bus_req, bus_burst;
  logic [DW-1:0] fetch_data;
  logic [AW-1:0] bus_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ci_fetch_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_type(req_type), .req_inhibit(req_inhibit),
    .beat_valid(beat_valid), .beat_data(beat_data), .wr_valid(wr_valid),
    .wr_line(wr_line), .inval_all(inval_all), .icache_fill(icache_fill),
    .fetch_hit(fetch_hit), .fetch_data(fetch_data), .fetch_stall(fetch_stall),
    .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr)
  );

  function automatic logic [AW-1:0] waddr(input int line, input int w);
    return AW'(line * WORDS + w);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic fetch_set(input logic [AW-1:0] a, input logic [1:0] t, input logic inh);
    req_valid = 1'b1; req_addr = a; req_type = t; req_inhibit = inh;
  endtask

  task automatic feed_beats(input logic [DW-1:0] base);
    for (int w = 0; w < WORDS; w++) begin
      beat_valid = 1'b1; beat_data = base + DW'(w);
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  task automatic fill_line(input int line, input logic [DW-1:0] base);
    @(negedge clk);
    fetch_set(waddr(line, 1), 2'd0, 1'b1);
    #1;
    check("R3", "burst req", {bus_req, bus_burst}, 2'b11);
    check("R3", "burst addr", bus_addr, waddr(line, 0));
    @(negedge clk);
    req_valid = 1'b0;
    feed_beats(base);
  endtask

  task automatic expect_hits(input string req, input int line, input logic [DW-1:0] base);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      fetch_set(waddr(line, w), 2'd0, 1'b1);
      #1;
      check(req, "hit", {fetch_hit, bus_req, fetch_stall}, 3'b100);
      check(req, "data", fetch_data, base + DW'(w));
      req_valid = 1'b0;
    end
  endtask

  task automatic expect_miss(input string req, input int line);
    @(negedge clk);
    fetch_set(waddr(line, 0), 2'd0, 1'b1);
    #1;
    check(req, "miss starts burst", {fetch_hit, bus_req, bus_burst}, 3'b011);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R9", "idle outputs", {fetch_hit, fetch_stall, bus_req}, 3'b000);
    expect_miss("R9", 4);
  endtask

  task automatic t_fill_and_hit();
    fill_line(1, 32'h0000_1100);
    expect_hits("R4", 1, 32'h0000_1100);
  endtask

  task automatic t_stall();
    @(negedge clk);
    fetch_set(waddr(5, 0), 2'd0, 1'b1);
    #1; check("R3", "burst start", {bus_req, bus_burst}, 2'b11);
    @(negedge clk);
    fetch_set(waddr(5, 2), 2'd0, 1'b1);
    beat_valid = 1'b1; beat_data = 32'h500;
    #1; check("R5", "stall word absent", {fetch_stall, fetch_hit, bus_req}, 3'b100);
    @(negedge clk);
    fetch_set(waddr(9, 0), 2'd0, 1'b1);
    beat_data = 32'h501;
    #1; check("R5", "stall other line", {fetch_stall, fetch_hit, bus_req}, 3'b100);
    @(negedge clk);
    fetch_set(waddr(5, 2), 2'd0, 1'b1);
    beat_data = 32'h502;
    #1; check("R5", "stall until edge", {fetch_stall, fetch_hit}, 2'b10);
    @(negedge clk);
    beat_data = 32'h503;
    #1; check("R5", "hit after beat", {fetch_stall, fetch_hit, bus_req}, 3'b010);
    check("R5", "data", fetch_data, 32'h502);
    @(negedge clk);
    req_valid = 1'b0; beat_valid = 1'b0;
    expect_hits("R3", 5, 32'h500);
  endtask

  task automatic t_drop();
    fill_line(3, 32'h300);
    @(negedge clk); inval_all = 1'b1;
    @(negedge clk); inval_all = 1'b0;
    expect_miss("R6", 3);
    fill_line(7, 32'h700);
    @(negedge clk); icache_fill = 1'b1;
    @(negedge clk); icache_fill = 1'b0;
    expect_miss("R6", 7);
    // abort a running fill, then send the remaining beat
    @(negedge clk); fetch_set(waddr(8, 0), 2'd0, 1'b1);
    @(negedge clk); req_valid = 1'b0; beat_valid = 1'b1; beat_data = 32'h800;
    @(negedge clk); beat_data = 32'h801;
    @(negedge clk); beat_data = 32'h802; inval_all = 1'b1;
    @(negedge clk); beat_data = 32'h803; inval_all = 1'b0;
    @(negedge clk); beat_valid = 1'b0;
    expect_miss("R6", 8);
  endtask

  task automatic t_replace_and_write();
    fill_line(1, 32'h100);
    fill_line(2, 32'h200);
    expect_miss("R7", 1);
    @(negedge clk); wr_valid = 1'b1; wr_line = TAGW'(2);
    @(negedge clk); wr_valid = 1'b0;
    expect_hits("R8", 2, 32'h200);
  endtask

  task automatic t_enable_and_type();
    @(negedge clk); buf_en = 1'b0;
    fetch_set(waddr(2, 3), 2'd0, 1'b1);
    #1; check("R1", "disabled single", {fetch_hit, fetch_stall, bus_req, bus_burst}, 4'b0010);
    check("R1", "single addr", bus_addr, waddr(2, 3));
    req_valid = 1'b0;
    @(negedge clk); buf_en = 1'b1;
    expect_hits("R1", 2, 32'h200);
    @(negedge clk); fetch_set(waddr(2, 1), 2'd1, 1'b1);
    #1; check("R2", "type1 single", {fetch_hit, bus_req, bus_burst}, 3'b010);
    req_type = 2'd3;
    #1; check("R2", "type3 single", {fetch_hit, bus_req, bus_burst}, 3'b010);
    req_type = 2'd0; req_inhibit = 1'b0;
    #1; check("R2", "cacheable ignored", {fetch_hit, bus_req}, 2'b00);
    req_valid = 1'b0;
  endtask

  task automatic t_start_with_drop();
    @(negedge clk);
    fetch_set(waddr(11, 0), 2'd0, 1'b1); inval_all = 1'b1;
    #1; check("R10", "burst with drop", {bus_req, bus_burst}, 2'b11);
    @(negedge clk); req_valid = 1'b0; inval_all = 1'b0;
    feed_beats(32'hB00);
    expect_hits("R10", 11, 32'hB00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fill_and_hit();
    t_stall();
    t_drop();
    t_replace_and_write();
    t_enable_and_type();
    t_start_with_drop();
    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end
endmodule